// File: doc/BRIEF.md
# Per-Frame Pixel Level Statistics Counter

This block watches an 8-bit pixel stream and counts, for each frame, how many qualified pixels are very dark and how many are bright. A pixel is very dark when its value is below a low threshold. It is bright when its value is above a high threshold. Only pixels marked by the data-valid strobe take part.

When the frame sync input goes high, the block publishes one eighth of each raw count as a 16-bit statistics value. It clears both raw counters in that same cycle so that the next frame starts from zero. The two published values are read-only data for a register interface. An external controller reads them to steer the sensor's reset reference level. That control loop is outside this block.

The raw counters are 19 bits wide, which holds any full sensor frame. A raw counter stops at its all-ones value instead of wrapping. A published value stops at the all-ones value of its output width.

Top module: `pixlevel_stats`

## Requirements
- R1: After reset both published values are 0, and they stay 0 until the first rising edge of `vsync`, even while pixels are being counted.
- R2: A pixel with `pix_valid` high and a value below `DARK_LIMIT` (default 3, so the values 0, 1 and 2) increments the dark count.
- R3: A pixel with `pix_valid` high and a value above `BRIGHT_LIMIT` (default 123, so the values 124 to 255) increments the bright count.
- R4: A pixel with `pix_valid` low changes no count. A pixel with a value from 3 to 123 inclusive changes no count. A frame that contains no qualifying pixel publishes 0.
- R5: Each published value is the frame's raw count shifted right by 3, which is floor(count / 8).
- R6: The published values change only on the clock edge where `vsync` is sampled high after being sampled low. They hold their value on every other cycle, including while `vsync` stays high.
- R7: Both raw counts restart on the cycle of the `vsync` rising edge. A qualifying pixel presented in that cycle is counted into the new frame, and so is any qualifying pixel presented while `vsync` stays high.
- R8: A raw count stops at all ones and does not wrap. When the shifted count does not fit in `OUT_W` bits, the published value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_data | input | PIX_W (8) | Pixel value |
| pix_valid | input | 1 | High when `pix_data` carries a pixel to be counted |
| vsync | input | 1 | Frame sync; its rising edge ends the frame |
| dark_count | output | OUT_W (16) | Published dark-pixel statistic, raw count / 8 |
| bright_count | output | OUT_W (16) | Published bright-pixel statistic, raw count / 8 |

## Verification
The assertions check four things on every cycle:
- The published values move only on a detected frame edge.
- The frame edge detector never fires two cycles in a row.
- A raw counter holds its value when no pixel is valid, and it restarts at 0 or 1 on a frame edge.
- A full raw counter stays full, and an oversized count publishes all ones.

Some properties can only be shown by the bench's scenarios:
- The exact threshold boundaries, checked with repeated sweeps over all 256 pixel values, valid and invalid.
- The floor-by-eight arithmetic.
- The attribution of pixels that arrive in the edge cycle and during a long `vsync` high.
- Saturation, which is reached through a second, narrow instance.

// File: rtl/pixlevel_stats_pkg.sv
// Package: shared types for the pixel level statistics block.
// Assumes nothing beyond IEEE 1800-2017.
package pixlevel_stats_pkg;
    // Direction of a threshold comparison.
    typedef enum logic {
        CMP_BELOW = 1'b0,
        CMP_ABOVE = 1'b1
    } cmp_kind_e;
endpackage

// File: rtl/pixlevel_edge.sv
// Module: pixlevel_edge
// Detects the rising edge of the frame sync input. It emits a one-cycle
// frame_tick in the cycle where vsync is sampled high after being low.
// Assumes that vsync is synchronous to clk.
module pixlevel_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic frame_tick
);
    logic vsync_q;

    // Remember the previous vsync sample.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    // The tick is high for the first cycle of each vsync high period.
    always_comb frame_tick = vsync && !vsync_q;

    // R6: a frame edge lasts a single cycle.
    p_single_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick);
endmodule

// File: rtl/pixlevel_counter.sv
// Module: pixlevel_counter
// Counts the valid pixels that meet one threshold comparison. On clear it
// restarts at 0, or at 1 when the current pixel qualifies. It stops at all
// ones instead of wrapping.
// Assumes that clear is a single-cycle frame edge.
module pixlevel_counter
    import pixlevel_stats_pkg::*;
#(
    parameter int        PIX_W  = 8,
    parameter int        RAW_W  = 19,
    parameter cmp_kind_e KIND   = CMP_BELOW,
    parameter int        THRESH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix,
    input  logic             pix_valid,
    input  logic             clear,
    output logic [RAW_W-1:0] raw
);
    localparam logic [RAW_W-1:0] RAW_FULL = {RAW_W{1'b1}};
    localparam logic [PIX_W-1:0] THR      = PIX_W'(THRESH);

    logic meets;
    logic hit;

    // Select the comparison direction at elaboration.
    generate
        if (KIND == CMP_BELOW) begin : g_below
            always_comb meets = (pix < THR);
        end else begin : g_above
            always_comb meets = (pix > THR);
        end
    endgenerate

    // A pixel counts only when it is qualified by the strobe.
    always_comb hit = pix_valid && meets;

    // Raw count: restart on a frame edge, otherwise add up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                       raw <= '0;
        else if (clear)                   raw <= {{(RAW_W-1){1'b0}}, hit};
        else if (hit && raw != RAW_FULL)  raw <= raw + 1'b1;
    end

    // R7: after a frame edge the count is 0 or 1.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (raw <= RAW_W'(1)));
    // R4: an unqualified cycle leaves the count alone.
    p_invalid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !pix_valid) |=> $stable(raw));
    // R8: a full count stays full.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && raw == RAW_FULL) |=> (raw == RAW_FULL));
endmodule

// File: rtl/pixlevel_publish.sv
// Module: pixlevel_publish
// Scales a raw count down by 2**SHIFT and saturates it to OUT_W bits. It
// holds the result between frame edges.
// Assumes that load is a single-cycle frame edge.
module pixlevel_publish #(
    parameter int RAW_W = 19,
    parameter int OUT_W = 16,
    parameter int SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RAW_W-1:0] raw,
    output logic [OUT_W-1:0] stat
);
    localparam int WIDE_W = RAW_W + OUT_W;

    logic [WIDE_W-1:0] wide;
    logic              too_big;
    logic [OUT_W-1:0]  clipped;

    // Scale the raw count by the power-of-two divisor.
    always_comb wide = {{OUT_W{1'b0}}, raw} >> SHIFT;

    // Saturate when the scaled value needs more than OUT_W bits.
    always_comb begin
        too_big = |wide[WIDE_W-1:OUT_W];
        clipped = too_big ? {OUT_W{1'b1}} : wide[OUT_W-1:0];
    end

    // Capture the statistic on the frame edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)    stat <= '0;
        else if (load) stat <= clipped;
    end

    // R6: the published value holds between frame edges.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(stat));
    // R8: an oversized count publishes all ones.
    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && too_big) |=> (&stat));
endmodule

// File: rtl/pixlevel_stats.sv
// Module: pixlevel_stats (top)
// Per-frame counts of dark and bright valid pixels. Each count is published
// as count / 8 on the vsync rising edge, and the raw counters restart in the
// same cycle.
// Assumes that all inputs are synchronous to clk.
module pixlevel_stats
    import pixlevel_stats_pkg::*;
#(
    parameter int PIX_W        = 8,
    parameter int RAW_W        = 19,
    parameter int OUT_W        = 16,
    parameter int SHIFT        = 3,
    parameter int DARK_LIMIT   = 3,
    parameter int BRIGHT_LIMIT = 123
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    input  logic             vsync,
    output logic [OUT_W-1:0] dark_count,
    output logic [OUT_W-1:0] bright_count
);
    localparam int N_STAT = 2;

    logic             frame_tick;
    logic [RAW_W-1:0] raw   [N_STAT];
    logic [OUT_W-1:0] stat  [N_STAT];

    pixlevel_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .frame_tick (frame_tick)
    );

    // Channel 0 counts dark pixels and channel 1 counts bright pixels.
    generate
        for (genvar g = 0; g < N_STAT; g++) begin : g_chan
            localparam cmp_kind_e KIND = (g == 0) ? CMP_BELOW : CMP_ABOVE;
            localparam int        THR  = (g == 0) ? DARK_LIMIT : BRIGHT_LIMIT;

            pixlevel_counter #(
                .PIX_W  (PIX_W),
                .RAW_W  (RAW_W),
                .KIND   (KIND),
                .THRESH (THR)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .pix       (pix_data),
                .pix_valid (pix_valid),
                .clear     (frame_tick),
                .raw       (raw[g])
            );

            pixlevel_publish #(
                .RAW_W (RAW_W),
                .OUT_W (OUT_W),
                .SHIFT (SHIFT)
            ) u_pub (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (frame_tick),
                .raw   (raw[g]),
                .stat  (stat[g])
            );
        end
    endgenerate

    // Drive the register-facing outputs.
    always_comb begin
        dark_count   = stat[0];
        bright_count = stat[1];
    end

    // R1: a cycle in reset leaves both values at zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (dark_count == '0 && bright_count == '0));
endmodule

// File: tb/pixlevel_stats_test.sv
// Bench for pixlevel_stats. It runs sweeps over all pixel values and checks
// the results against counts computed in the bench. A second, narrow
// instance makes saturation reachable.
module pixlevel_stats_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_data = '0;
    logic       pix_valid = 1'b0;
    logic       vsync = 1'b0;
    logic [15:0] dark_count, bright_count;
    logic [3:0]  sat_dark, sat_bright;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Model state: raw counts and expected published values.
    int m_dark = 0, m_bright = 0, e_dark = 0, e_bright = 0;
    int s_dark = 0, s_bright = 0, q_dark = 0, q_bright = 0;
    bit prev_vs = 1'b0;
    string tag = "R1 reset";

    always #10 clk = ~clk;

    pixlevel_stats uut (
        .clk (clk), .rst_n (rst_n), .pix_data (pix_data), .pix_valid (pix_valid),
        .vsync (vsync), .dark_count (dark_count), .bright_count (bright_count)
    );

    pixlevel_stats #(.RAW_W (8), .OUT_W (4)) uut_sat (
        .clk (clk), .rst_n (rst_n), .pix_data (pix_data), .pix_valid (pix_valid),
        .vsync (vsync), .dark_count (sat_dark), .bright_count (sat_bright)
    );

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int pub(input int c, input int omax);
        return ((c >> 3) > omax) ? omax : (c >> 3);
    endfunction

    function automatic int bump(input int c, input bit h, input int rmax);
        return (h && c < rmax) ? c + 1 : c;
    endfunction

    task automatic check_all();
        check(int'(dark_count),   e_dark,   {tag, " dark"});
        check(int'(bright_count), e_bright, {tag, " bright"});
        check(int'(sat_dark),     q_dark,   {tag, " narrow dark"});
        check(int'(sat_bright),   q_bright, {tag, " narrow bright"});
    endtask

    // One clock cycle of stimulus, then a model update and a compare.
    task automatic step(input logic [7:0] p, input logic v, input logic vs);
        bit lo, hi;
        pix_data = p; pix_valid = v; vsync = vs;
        @(posedge clk);
        lo = v && (p < 8'd3);
        hi = v && (p > 8'd123);
        if (vs && !prev_vs) begin
            e_dark = pub(m_dark, 65535); e_bright = pub(m_bright, 65535);
            q_dark = pub(s_dark, 15);    q_bright = pub(s_bright, 15);
            m_dark = lo; m_bright = hi; s_dark = lo; s_bright = hi;
        end else begin
            m_dark = bump(m_dark, lo, 524287); m_bright = bump(m_bright, hi, 524287);
            s_dark = bump(s_dark, lo, 255);    s_bright = bump(s_bright, hi, 255);
        end
        prev_vs = vs;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then counting with no frame edge yet.
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        tag = "R1 before first vsync";
        for (int i = 0; i < 10; i++) step(8'd0, 1'b1, 1'b0);
        check(int'(dark_count), 0, "R1 still zero");
        tag = "R5 first frame";
        step(8'd200, 1'b0, 1'b1);
        check(int'(dark_count), 1, "R5 10/8 floor");
        check(int'(bright_count), 0, "R5 bright empty");

        // R2, R3, R4: eight sweeps over all 256 values, each valid and invalid.
        tag = "R4 sweep";
        for (int r = 0; r < 8; r++)
            for (int v = 0; v < 256; v++) begin
                step(8'(v), 1'b1, 1'b0);
                step(8'(v), 1'b0, 1'b0);
            end
        step(8'd255, 1'b0, 1'b1);
        check(int'(dark_count), 3, "R2 dark values 0..2 x8");
        check(int'(bright_count), 132, "R3 bright values 124..255 x8");
        check(int'(sat_bright), 15, "R8 narrow saturation");

        // R5: values at the threshold boundaries.
        tag = "R5 boundary";
        for (int i = 0; i < 17; i++) step(8'd2, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(8'd2, 1'b0, 1'b0);
        for (int i = 0; i < 50; i++) step(8'd3, 1'b1, 1'b0);
        for (int i = 0; i < 50; i++) step(8'd123, 1'b1, 1'b0);
        for (int i = 0; i < 9; i++) step(8'd124, 1'b1, 1'b0);
        step(8'd0, 1'b0, 1'b0);
        step(8'd200, 1'b0, 1'b1);
        check(int'(dark_count), 2, "R5 dark 17/8");
        check(int'(bright_count), 1, "R5 bright 9/8");

        // R6, R7: long vsync high period with counted pixels.
        tag = "R6 long vsync";
        step(8'd0, 1'b0, 1'b0);
        step(8'd0, 1'b1, 1'b1);
        check(int'(dark_count), 0, "R7 publish on edge");
        for (int i = 0; i < 4; i++) begin
            step(8'd0, 1'b1, 1'b1);
            check(int'(dark_count), 0, "R6 held while vsync high");
        end
        for (int i = 0; i < 3; i++) step(8'd0, 1'b1, 1'b0);
        step(8'd200, 1'b0, 1'b1);
        check(int'(dark_count), 1, "R7 edge-cycle pixels counted (8/8)");
        check(int'(bright_count), 0, "R7 bright empty");

        // R4: empty frame.
        tag = "R4 empty";
        step(8'd0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(8'd60, 1'b1, 1'b0);
        step(8'd60, 1'b1, 1'b1);
        check(int'(dark_count), 0, "R4 empty dark");
        check(int'(bright_count), 0, "R4 empty bright");

        // R8: raw and output saturation in the narrow instance.
        tag = "R8 saturation";
        step(8'd0, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) step(8'd1, 1'b1, 1'b0);
        for (int i = 0; i < 100; i++) step(8'd250, 1'b1, 1'b0);
        step(8'd0, 1'b0, 1'b1);
        check(int'(dark_count), 37, "R5 dark 300/8");
        check(int'(sat_dark), 15, "R8 narrow dark saturated");
        check(int'(bright_count), 12, "R5 bright 100/8");
        check(int'(sat_bright), 12, "R8 narrow bright unsaturated");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule